// File: doc/BRIEF.md
# YUV 4:2:2 output formatter

This block sits at the end of a camera pixel pipeline. It receives one 4:4:4 pixel every second clock cycle, as an 8-bit luma sample, two 8-bit colour-difference samples (Cb, Cr) and four timing flags (line active, field active, line sync and field parity). It halves the chroma rate to 4:2:2 and presents the result on a two-bus video port.

The block runs from a double-rate clock. An internal phase bit splits each pixel period into two cycles. A static mode input chooses the bus layout. In the wide layout, the luma bus carries Y on every pixel and the chroma bus alternates Cb and Cr. In the narrow layout, the luma bus carries one byte per cycle in the order Cb, Y, Cr, Y, and the chroma bus rests at mid-scale.

Each chroma sample is the rounded mean of an even/odd pixel pair. It is sited on the even pixel, and every line's pair counting restarts with Cb. The block also provides:
- a Cb marker,
- a field sync that lasts three lines, with an edge phase that depends on the field,
- pixel-rate and double-rate clock enables,
- a registered enable for the output pad drivers.

Top module: `yuv422_out_formatter`

## Requirements
- R1: With `mode8_i` low, `y_o` holds the pixel's Y for both cycles of its output slot. `c_o` carries Cb on the first valid pixel of each run and on every second valid pixel after it, and carries Cr on the others.
- R2: With `mode8_i` high, `y_o` carries the slot's chroma byte in its first cycle and the slot's Y in its second, giving the order Cb, Y, Cr, Y. In this mode `c_o` is 0x80.
- R3: The Cb of an even/odd pair is (Cb_even + Cb_odd + 1) >> 1, and the Cr is formed the same way from the Cr inputs. A valid pixel that has no odd partner (an odd-length run) uses its own chroma.
- R4: `bflag_o` is 1 exactly in the output slots of valid pixels that carry Cb, and 0 in all other slots.
- R5: A pixel is valid only when `hact_i` and `vact_i` are both 1. In an invalid slot, luma bytes are 0x10 and chroma bytes are 0x80. `hsync_o`, `hact_o` and `vact_o` repeat their inputs with the same delay as the data.
- R6: `vsync_o` goes low for exactly 3 lines at the start of each field. In an odd field (field 0), its edges occur together with the falling edge of `hsync_o`, while `hsync_o` and `hact_o` are low. In an even field (field 1), its edges occur together with the rising edge of `hact_o`, while `hsync_o` and `hact_o` are high.
- R7: `field_o` repeats `field_i`, delayed with the data: 0 means odd and 1 means even.
- R8: `pad_en_o`, which drives the enables of all output pads (data, sync, clock enables and flag), equals `out_en_i` from the previous cycle.
- R9: `ce1x_o` is high in every second cycle, and the inputs are captured at the end of those cycles. `ce2x_o` is high in every cycle. Both are low during reset.
- R10: The outputs for a captured pixel are updated on the fourth rising edge after the capturing edge and held for two cycles.
- R11: During reset, `y_o` is 0x10, `c_o` is 0x80, `hsync_o`, `vsync_o` and `field_o` are 1, and `hact_o`, `vact_o`, `bflag_o` and `pad_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| mode8_i | input | 1 | 1: single multiplexed byte bus, 0: luma plus chroma buses |
| out_en_i | input | 1 | Requests that the output pads be driven |
| y_i | input | DATA_W | Luma sample |
| cb_i | input | DATA_W | Blue colour-difference sample |
| cr_i | input | DATA_W | Red colour-difference sample |
| hact_i | input | 1 | Line active |
| vact_i | input | 1 | Field active |
| hsync_i | input | 1 | Line sync, low at line start |
| field_i | input | 1 | Field parity, 0 odd, 1 even |
| y_o | output | DATA_W | Luma bus, or the multiplexed byte bus |
| c_o | output | DATA_W | Chroma bus, or mid-scale in narrow mode |
| hsync_o | output | 1 | Delayed line sync |
| vsync_o | output | 1 | Field sync, low for three lines |
| hact_o | output | 1 | Delayed line active |
| vact_o | output | 1 | Delayed field active |
| field_o | output | 1 | Delayed field parity |
| bflag_o | output | 1 | Cb present in the current slot |
| ce1x_o | output | 1 | Pixel-rate enable, high in capture cycles |
| ce2x_o | output | 1 | Double-rate enable |
| pad_en_o | output | 1 | Drive enable for all output pads |

## Verification
A pixel driven in a `ce1x_o` cycle is captured at the end of that cycle. Its outputs change on the fourth edge after capture, so its first byte is on the bus in the fifth cycle after the drive and its second byte in the sixth. The monitor waits exactly five cycles after the first push and then reads two cycles per queued item. It never polls for a result, so any slip in latency or byte order shows up as a mismatch. The pad enable is checked one cycle after `out_en_i` changes. The reset values are read while reset is held.

// File: rtl/yuvfmt_pkg.sv
package yuvfmt_pkg;

   // timing flags that travel with each pixel
   typedef struct packed {
      logic hs;   // line sync, low at line start
      logic ha;   // line active
      logic va;   // field active
      logic fld;  // field parity
   } vid_sync_t;

   localparam vid_sync_t SYNC_IDLE = '{hs: 1'b1, ha: 1'b0, va: 1'b0, fld: 1'b1};

endpackage

// File: rtl/yuvfmt_pair_stage.sv
// Two-slot pixel pipe that pairs even/odd pixels and forms 4:2:2 chroma.
module yuvfmt_pair_stage
   import yuvfmt_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit ROUND_UP = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          pix_ce,
   input  logic [DW-1:0] y_i,
   input  logic [DW-1:0] u_i,
   input  logic [DW-1:0] v_i,
   input  vid_sync_t     sync_i,
   output logic [DW-1:0] y_o,
   output logic [DW-1:0] chroma_o,
   output logic          cb_o,
   output logic          valid_o,
   output vid_sync_t     sync_o
);
   localparam logic [DW-1:0] NEUTRAL = {1'b1, {(DW-1){1'b0}}};

   typedef struct packed {
      logic [DW-1:0] y;
      logic [DW-1:0] u;
      logic [DW-1:0] v;
      logic          par;   // 1: odd position within the active run
      logic          val;
      vid_sync_t     s;
   } slot_t;

   slot_t         s0, s1;
   logic [DW-1:0] v_hold;
   logic          in_val;
   logic [DW-1:0] pu, pv;
   logic [DW:0]   u_sum, v_sum;
   logic [DW-1:0] u_avg, v_avg;

   assign in_val = sync_i.ha & sync_i.va;

   // partner of an even pixel: next slot if valid, else itself
   assign pu    = s0.val ? s0.u : s1.u;
   assign pv    = s0.val ? s0.v : s1.v;
   assign u_sum = {1'b0, s1.u} + {1'b0, pu};
   assign v_sum = {1'b0, s1.v} + {1'b0, pv};

   generate
      if (ROUND_UP) begin : g_round
         logic [DW:0] u_rnd, v_rnd;
         assign u_rnd = u_sum + (DW+1)'(1);
         assign v_rnd = v_sum + (DW+1)'(1);
         assign u_avg = u_rnd[DW:1];
         assign v_avg = v_rnd[DW:1];
      end else begin : g_trunc
         assign u_avg = u_sum[DW:1];
         assign v_avg = v_sum[DW:1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         s0     <= '0;
         s0.s   <= SYNC_IDLE;
         s1     <= '0;
         s1.s   <= SYNC_IDLE;
         v_hold <= NEUTRAL;
      end else if (pix_ce) begin
         s1     <= s0;
         s0.y   <= y_i;
         s0.u   <= u_i;
         s0.v   <= v_i;
         s0.val <= in_val;
         s0.par <= in_val & s0.val & ~s0.par;
         s0.s   <= sync_i;
         if (s1.val && !s1.par) begin
            v_hold <= v_avg;
         end
      end
   end

   assign y_o      = s1.y;
   assign valid_o  = s1.val;
   assign cb_o     = s1.val & ~s1.par;
   assign sync_o   = s1.s;
   assign chroma_o = !s1.val ? NEUTRAL : (!s1.par ? u_avg : v_hold);

   // an even pixel followed by a valid one must hand over to its odd partner
   p_cr_follows_cb_r1: assert property (@(posedge clk) disable iff (rst)
      (pix_ce && s1.val && !s1.par && s0.val) |=> (s1.val && s1.par));

endmodule

// File: rtl/yuvfmt_vsync.sv
// Field sync: low for LINES lines, edge phase chosen by field parity.
module yuvfmt_vsync #(
   parameter int LINES = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic pix_ce,
   input  logic cur_hs,
   input  logic cur_ha,
   input  logic cur_fld,
   input  logic prv_hs,
   input  logic prv_ha,
   input  logic prv_fld,
   output logic vs_o
);
   localparam int CW = $clog2(LINES + 1);

   logic          armed;
   logic [CW-1:0] cnt;
   logic          fld_chg, evt, go;

   assign fld_chg = cur_fld != prv_fld;
   // even field: hact rising; odd field: hsync falling
   assign evt     = cur_fld ? (cur_ha & ~prv_ha) : (~cur_hs & prv_hs);
   assign go      = (armed | fld_chg) & evt;

   always_ff @(posedge clk) begin
      if (rst) begin
         vs_o  <= 1'b1;
         armed <= 1'b0;
         cnt   <= '0;
      end else if (pix_ce) begin
         if (vs_o) begin
            if (go) begin
               vs_o  <= 1'b0;
               cnt   <= CW'(LINES);
               armed <= 1'b0;
            end else if (fld_chg) begin
               armed <= 1'b1;
            end
         end else if (evt) begin
            if (cnt == CW'(1)) begin
               vs_o <= 1'b1;
            end else begin
               cnt <= cnt - CW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/yuvfmt_out_fmt.sv
// Output registers and byte multiplexing for the two bus layouts.
module yuvfmt_out_fmt
   import yuvfmt_pkg::*;
#(
   parameter int            DW      = 8,
   parameter logic [DW-1:0] BLANK_L = 8'h10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          pix_ce,
   input  logic          mode8,
   input  logic [DW-1:0] y_i,
   input  logic [DW-1:0] chroma_i,
   input  logic          cb_i,
   input  logic          valid_i,
   input  vid_sync_t     sync_i,
   output logic [DW-1:0] y_o,
   output logic [DW-1:0] c_o,
   output logic          bflag_o,
   output vid_sync_t     sync_o
);
   localparam logic [DW-1:0] NEUTRAL = {1'b1, {(DW-1){1'b0}}};

   logic [DW-1:0] luma_sel, chr_sel, luma_h;

   assign luma_sel = valid_i ? y_i      : BLANK_L;
   assign chr_sel  = valid_i ? chroma_i : NEUTRAL;

   always_ff @(posedge clk) begin
      if (rst) begin
         y_o     <= BLANK_L;
         c_o     <= NEUTRAL;
         bflag_o <= 1'b0;
         sync_o  <= SYNC_IDLE;
         luma_h  <= BLANK_L;
      end else if (pix_ce) begin
         luma_h  <= luma_sel;
         y_o     <= mode8 ? chr_sel : luma_sel;
         c_o     <= mode8 ? NEUTRAL : chr_sel;
         bflag_o <= valid_i & cb_i;
         sync_o  <= sync_i;
      end else if (mode8) begin
         y_o <= luma_h;
      end
   end

   p_neutral8_r2: assert property (@(posedge clk) disable iff (rst)
      (pix_ce && mode8) |=> (c_o == NEUTRAL));

   p_bflag_valid_r4: assert property (@(posedge clk) disable iff (rst)
      bflag_o |-> (sync_o.ha && sync_o.va));

   p_byte_hold16_r1: assert property (@(posedge clk) disable iff (rst)
      (!pix_ce && !mode8) |=> $stable(y_o));

endmodule

// File: rtl/yuv422_out_formatter.sv
module yuv422_out_formatter
   import yuvfmt_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int VS_LINES = 3,
   parameter int BLANK_Y  = 16,
   parameter bit ROUND_UP = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode8_i,
   input  logic              out_en_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic [DATA_W-1:0] cb_i,
   input  logic [DATA_W-1:0] cr_i,
   input  logic              hact_i,
   input  logic              vact_i,
   input  logic              hsync_i,
   input  logic              field_i,
   output logic [DATA_W-1:0] y_o,
   output logic [DATA_W-1:0] c_o,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              hact_o,
   output logic              vact_o,
   output logic              field_o,
   output logic              bflag_o,
   output logic              ce1x_o,
   output logic              ce2x_o,
   output logic              pad_en_o
);
   localparam logic [DATA_W-1:0] BLANK_L = DATA_W'(BLANK_Y);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (VS_LINES < 1) begin : g_bad_lines
         $error("VS_LINES must be at least 1");
      end
      if (BLANK_Y < 0 || BLANK_Y >= (1 << DATA_W)) begin : g_bad_blank
         $error("BLANK_Y does not fit DATA_W");
      end
   endgenerate

   logic          ph, ce2x_q, pad_q;
   vid_sync_t     in_sync, st_sync, out_sync;
   logic [DATA_W-1:0] st_y, st_c;
   logic          st_cb, st_val;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph     <= 1'b0;
         ce2x_q <= 1'b0;
         pad_q  <= 1'b0;
      end else begin
         ph     <= ~ph;
         ce2x_q <= 1'b1;
         pad_q  <= out_en_i;
      end
   end

   assign in_sync = '{hs: hsync_i, ha: hact_i, va: vact_i, fld: field_i};

   yuvfmt_pair_stage #(.DW(DATA_W), .ROUND_UP(ROUND_UP)) u_pair (
      .clk      (clk),
      .rst      (rst),
      .pix_ce   (ph),
      .y_i      (y_i),
      .u_i      (cb_i),
      .v_i      (cr_i),
      .sync_i   (in_sync),
      .y_o      (st_y),
      .chroma_o (st_c),
      .cb_o     (st_cb),
      .valid_o  (st_val),
      .sync_o   (st_sync)
   );

   yuvfmt_out_fmt #(.DW(DATA_W), .BLANK_L(BLANK_L)) u_out (
      .clk      (clk),
      .rst      (rst),
      .pix_ce   (ph),
      .mode8    (mode8_i),
      .y_i      (st_y),
      .chroma_i (st_c),
      .cb_i     (st_cb),
      .valid_i  (st_val),
      .sync_i   (st_sync),
      .y_o      (y_o),
      .c_o      (c_o),
      .bflag_o  (bflag_o),
      .sync_o   (out_sync)
   );

   yuvfmt_vsync #(.LINES(VS_LINES)) u_vs (
      .clk     (clk),
      .rst     (rst),
      .pix_ce  (ph),
      .cur_hs  (st_sync.hs),
      .cur_ha  (st_sync.ha),
      .cur_fld (st_sync.fld),
      .prv_hs  (out_sync.hs),
      .prv_ha  (out_sync.ha),
      .prv_fld (out_sync.fld),
      .vs_o    (vsync_o)
   );

   assign hsync_o  = out_sync.hs;
   assign hact_o   = out_sync.ha;
   assign vact_o   = out_sync.va;
   assign field_o  = out_sync.fld;
   assign ce1x_o   = ph;
   assign ce2x_o   = ce2x_q;
   assign pad_en_o = pad_q;

   // odd field: field sync edges land on the line-sync falling edge
   p_vs_odd_r6: assert property (@(posedge clk) disable iff (rst)
      (($fell(vsync_o) || $rose(vsync_o)) && !field_o) |-> (!hsync_o && !hact_o));

   // even field: field sync edges land on the line-active rising edge
   p_vs_even_r6: assert property (@(posedge clk) disable iff (rst)
      (($fell(vsync_o) || $rose(vsync_o)) && field_o) |-> (hsync_o && hact_o));

endmodule

// File: tb/tb_yuv422_out_formatter.sv
`timescale 1ns/1ps
module tb_yuv422_out_formatter;

   localparam int LPX = 12;   // pixels per line
   localparam int HA0 = 4;    // first active pixel position
   localparam int NLN = 5;    // lines per field

   typedef struct {
      logic [7:0] b0, b1, c;
      logic bf, hs, ha, va, fld, vs;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode8 = 1'b0, oe = 1'b0;
   logic [7:0] yi = 8'h0, ui = 8'h0, vi = 8'h0;
   logic hai = 1'b0, vai = 1'b0, hsi = 1'b1, fdi = 1'b1;

   logic [7:0] y_o, c_o;
   logic hsync_o, vsync_o, hact_o, vact_o, field_o, bflag_o, ce1x_o, ce2x_o, pad_en_o;

   int n_chk = 0, n_err = 0;
   exp_t q[$];
   bit drv_done;
   bit vs_m;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   yuv422_out_formatter dut (
      .clk(clk), .rst(rst), .mode8_i(mode8), .out_en_i(oe),
      .y_i(yi), .cb_i(ui), .cr_i(vi), .hact_i(hai), .vact_i(vai),
      .hsync_i(hsi), .field_i(fdi),
      .y_o(y_o), .c_o(c_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
      .hact_o(hact_o), .vact_o(vact_o), .field_o(field_o), .bflag_o(bflag_o),
      .ce1x_o(ce1x_o), .ce2x_o(ce2x_o), .pad_en_o(pad_en_o)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] mean(logic [7:0] a, logic [7:0] b);
      logic [8:0] s;
      s = {1'b0, a} + {1'b0, b} + 9'd1;
      return s[8:1];
   endfunction

   task automatic drive_px(logic [7:0] y, logic [7:0] u, logic [7:0] v,
                           logic hs, logic ha, logic va, logic fd, exp_t e);
      do @(negedge clk); while (ce1x_o !== 1'b1);
      yi = y; ui = u; vi = v; hsi = hs; hai = ha; vai = va; fdi = fd;
      q.push_back(e);
   endtask

   task automatic drive_idle(logic fd);
      exp_t e;
      e.b0 = mode8 ? 8'h80 : 8'h10; e.b1 = 8'h10; e.c = 8'h80; e.bf = 1'b0;
      e.hs = 1'b1; e.ha = 1'b0; e.va = 1'b0; e.fld = fd; e.vs = vs_m;
      drive_px(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, fd, e);
   endtask

   task automatic drive_line(int f, int l);
      logic [7:0] ly[LPX], lu[LPX], lv[LPX];
      bit act[LPX], hal[LPX];
      int n, j, evt;
      logic fd;
      exp_t e;
      fd  = (f == 1);
      evt = fd ? HA0 : 0;
      n   = (l == 2) ? 5 : (l == 3) ? 4 : (l == 4) ? 1 : 6;
      for (int p = 0; p < LPX; p++) begin
         hal[p] = (p >= HA0) && (p < HA0 + n);
         act[p] = hal[p] && (l != 0);
         ly[p]  = 8'(17 * p + 29 * l + 5 * f + 16);
         lu[p]  = 8'(37 * p + 11 * l + 3 * f + 1);
         lv[p]  = 8'(53 * p + 7 * l + 200);
      end
      j = 0;
      for (int p = 0; p < LPX; p++) begin
         logic [7:0] chr;
         if (l == 0 && p == evt) vs_m = 1'b0;   // R6 start of field
         if (l == 3 && p == evt) vs_m = 1'b1;   // R6 three lines later
         e.bf = 1'b0;
         chr  = 8'h80;
         if (act[p]) begin
            if (j % 2 == 0) begin
               // R3 pair mean, lone pixel keeps its own chroma
               chr  = (p + 1 < LPX && act[p+1]) ? mean(lu[p], lu[p+1]) : lu[p];
               e.bf = 1'b1;
            end else begin
               chr = mean(lv[p-1], lv[p]);
            end
            j++;
         end
         e.c  = mode8 ? 8'h80 : chr;
         e.b0 = mode8 ? chr : (act[p] ? ly[p] : 8'h10);
         e.b1 = act[p] ? ly[p] : 8'h10;
         e.hs = (p >= 2); e.ha = hal[p]; e.va = (l != 0); e.fld = fd; e.vs = vs_m;
         drive_px(ly[p], lu[p], lv[p], (p >= 2), hal[p], (l != 0), fd, e);
      end
   endtask

   task automatic driver();
      for (int k = 0; k < 3; k++) drive_idle(1'b1);
      for (int f = 0; f < 3; f++)
         for (int l = 0; l < NLN; l++) drive_line(f, l);
      for (int k = 0; k < 3; k++) drive_idle(1'b0);
      drv_done = 1'b1;
   endtask

   task automatic monitor();
      exp_t e;
      string dt;
      wait (q.size() > 0);
      repeat (5) @(negedge clk);   // R10 output due five cycles after the drive
      dt = mode8 ? "R2 R10" : "R1 R10";
      forever begin
         e = q.pop_front();
         chk({dt, " first byte"}, y_o, e.b0);
         chk(mode8 ? "R2 chroma bus" : "R3 chroma", c_o, e.c);
         chk("R4 bflag", bflag_o, e.bf);
         chk("R5 hsync/hact/vact", {hsync_o, hact_o, vact_o}, {e.hs, e.ha, e.va});
         chk("R7 field", field_o, e.fld);
         chk("R6 vsync", vsync_o, e.vs);
         chk("R9 ce phase 0", {ce1x_o, ce2x_o}, 2'b01);
         @(negedge clk);
         chk({dt, " second byte"}, y_o, e.b1);
         chk("R9 ce phase 1", {ce1x_o, ce2x_o}, 2'b11);
         if (q.size() == 0 && drv_done) break;
         @(negedge clk);
      end
   endtask

   task automatic run_phase(logic m8);
      @(negedge clk);
      rst = 1'b1; mode8 = m8; oe = 1'b1;
      yi = 8'h0; ui = 8'h0; vi = 8'h0; hsi = 1'b1; hai = 1'b0; vai = 1'b0; fdi = 1'b1;
      repeat (4) @(negedge clk);
      // R11 reset state
      chk("R11 y_o", y_o, 8'h10);
      chk("R11 c_o", c_o, 8'h80);
      chk("R11 syncs", {hsync_o, vsync_o, field_o, hact_o, vact_o, bflag_o}, 6'b111000);
      chk("R11 pad_en", pad_en_o, 1'b0);
      chk("R9 ce in reset", {ce1x_o, ce2x_o}, 2'b00);
      rst = 1'b0;
      vs_m = 1'b1;
      drv_done = 1'b0;
      fork
         driver();
         monitor();
      join
      // R8 pad enable follows out_en_i one cycle later
      @(negedge clk); oe = 1'b0;
      @(negedge clk); chk("R8 pad off", pad_en_o, 1'b0);
      oe = 1'b1;
      @(negedge clk); chk("R8 pad on", pad_en_o, 1'b1);
   endtask

   initial begin
      run_phase(1'b0);
      run_phase(1'b1);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule